// File: doc/BRIEF.md
# Dual Circular Buffer Pointer Unit

This block keeps the pointer state of one serial channel's receive and transmit circular buffers, which sit side by side in a shared byte-wide memory. Each buffer is bounded by a programmable first address and a programmable last address, both inclusive, so its size need not be a power of two. The channel side fills the receive buffer and drains the transmit buffer. The host side drains the receive buffer by moving the receive read pointer and fills the transmit buffer by moving the transmit write pointer. Both sides reach the bytes through the same memory, which is modelled here as an internal RAM.

For each buffer the block reports occupancy, empty and full. It raises a receive service request once enough bytes have gathered and a transmit service request once the transmit buffer has drained low enough. A flush empties either buffer in one cycle. Received bytes that find the receive buffer full are dropped and recorded in a sticky overrun flag.

Top module: `ring_ptr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pointer loads the first address of its buffer and `overrun` clears. After reset both buffers read as empty.
- R2: A byte on `rx_data` with `rx_valid` high, while the receive buffer is not full, is stored at `in_wp`, and `in_wp` then advances by one. When `in_wp` advances from the last address it becomes the first address. The same wrap rule applies to `out_rp`.
- R3: When `rx_valid` is high while `in_full` is high, the byte is dropped, `in_wp` keeps its value and `overrun` is set. `overrun` stays set until the receive buffer is flushed.
- R4: A buffer is empty when its read pointer equals its write pointer. `tx_valid` is low when the transmit buffer is empty, and `tx_pop` then leaves `out_rp` unchanged.
- R5: A buffer is full when its write pointer is one below its read pointer, or when its read pointer is at the first address and its write pointer is at the last address.
- R6: Occupancy equals write pointer minus read pointer when the write pointer is not below the read pointer. Otherwise it equals buffer size (last − first + 1) minus (read pointer − write pointer). A full buffer therefore holds size − 1 bytes.
- R7: The host sets `in_rp` through `host_in_rp_we`/`host_in_rp` and sets `out_wp` through `host_out_wp_we`/`host_out_wp`. It has no way to write `in_wp` or `out_rp`.
- R8: `in_req` is high when the receive buffer is not empty and its occupancy is at least the smaller of `cfg_in_trig` and (last − first)/2, rounded down.
- R9: `out_req` is high when the transmit occupancy is at or below `cfg_out_low`.
- R10: `flush_in` or `flush_out` sets both pointers of its buffer to the buffer's first address at the next edge. This takes priority over any data movement or host pointer write in that cycle.
- R11: `tx_data` shows the memory byte at `out_rp`. `host_rdata` shows the memory byte at `host_addr`. A host write with `host_we` stores `host_wdata` at `host_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_in_first | input | AW | First address of receive buffer |
| cfg_in_last | input | AW | Last address of receive buffer (inclusive) |
| cfg_out_first | input | AW | First address of transmit buffer |
| cfg_out_last | input | AW | Last address of transmit buffer (inclusive) |
| cfg_in_trig | input | AW | Requested receive request threshold |
| cfg_out_low | input | AW | Transmit low-watermark |
| flush_in | input | 1 | Empty the receive buffer |
| flush_out | input | 1 | Empty the transmit buffer |
| rx_valid | input | 1 | Channel offers a received byte |
| rx_data | input | DW | Received byte |
| tx_pop | input | 1 | Channel consumes the byte at the read pointer |
| tx_valid | output | 1 | Transmit buffer holds a byte |
| tx_data | output | DW | Byte at transmit read pointer |
| host_we | input | 1 | Host memory write enable |
| host_addr | input | AW | Host memory address |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Host read byte |
| host_in_rp_we | input | 1 | Load receive read pointer |
| host_in_rp | input | AW | New receive read pointer |
| host_out_wp_we | input | 1 | Load transmit write pointer |
| host_out_wp | input | AW | New transmit write pointer |
| in_wp | output | AW | Receive write pointer |
| in_rp | output | AW | Receive read pointer |
| out_wp | output | AW | Transmit write pointer |
| out_rp | output | AW | Transmit read pointer |
| in_count | output | AW | Receive occupancy |
| out_count | output | AW | Transmit occupancy |
| in_empty | output | 1 | Receive buffer empty |
| in_full | output | 1 | Receive buffer full |
| out_empty | output | 1 | Transmit buffer empty |
| out_full | output | 1 | Transmit buffer full |
| in_req | output | 1 | Receive service request |
| out_req | output | 1 | Transmit service request |
| overrun | output | 1 | Sticky receive overrun |

## Verification
The assertions rely on two assumptions about the inputs. First, the first and last addresses stay constant outside reset, and each first address is at or below its last address. Second, any pointer value the host loads lies within its buffer. Under those conditions the wrap, flush and hold properties compare pointers with stable configuration values. The stimulus programs both windows before reset is released and never changes them afterwards. Every host pointer load in the stimulus uses an address inside the matching window, and memory writes from the host touch only the transmit window, so they never collide with receive writes.

// File: rtl/ring_pkg.sv
package ring_pkg;
   typedef enum logic {
      REQ_ON_FILL  = 1'b0,
      REQ_ON_DRAIN = 1'b1
   } req_rule_e;
endpackage

// File: rtl/ring_ram.sv
module ring_ram #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          wa_en,
   input  logic [AW-1:0] wa_addr,
   input  logic [DW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [AW-1:0] wb_addr,
   input  logic [DW-1:0] wb_data,
   input  logic [AW-1:0] ra_addr,
   output logic [DW-1:0] ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [DW-1:0] rb_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // port a (channel) is written last and wins a same-address collision
   always_ff @(posedge clk) begin
      if (wb_en) mem[wb_addr] <= wb_data;
      if (wa_en) mem[wa_addr] <= wa_data;
   end

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];
endmodule

// File: rtl/ring_ptr.sv
module ring_ptr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] first_a,
   input  logic [AW-1:0] last_a,
   input  logic          flush,
   input  logic          step,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] stepped;

   assign stepped = (ptr == last_a) ? first_a : ptr + AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) ptr <= first_a;
      else if (load)       ptr <= load_val;
      else if (step)       ptr <= stepped;
   end

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !flush && ptr == last_a) |=> (ptr == first_a));

   assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ptr == first_a));
endmodule

// File: rtl/ring_level.sv
module ring_level
   import ring_pkg::*;
#(
   parameter int        AW   = 8,
   parameter req_rule_e RULE = REQ_ON_FILL
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] first_a,
   input  logic [AW-1:0] last_a,
   input  logic [AW-1:0] wp,
   input  logic [AW-1:0] rp,
   input  logic [AW-1:0] thr,
   output logic [AW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          req
);
   localparam int CW = AW + 1;

   logic [CW-1:0] size;
   logic [CW-1:0] occ;

   assign size  = CW'(last_a) - CW'(first_a) + CW'(1);
   assign occ   = (wp >= rp) ? CW'(wp) - CW'(rp) : size - (CW'(rp) - CW'(wp));
   assign count = occ[AW-1:0];
   assign empty = (wp == rp);
   assign full  = (wp + AW'(1) == rp) || (rp == first_a && wp == last_a);

   generate
      if (RULE == REQ_ON_FILL) begin : g_fill
         logic [AW-1:0] half;
         logic [AW-1:0] eff;
         assign half = (last_a - first_a) >> 1;
         assign eff  = (thr > half) ? half : thr;
         assign req  = !empty && (count >= eff);
      end else begin : g_drain
         assign req = (count <= thr);
      end
   endgenerate

   assert_full_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (CW'(count) == size - CW'(1)));

   assert_empty_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (count == '0));
endmodule

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit
   import ring_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cfg_in_first,
   input  logic [AW-1:0] cfg_in_last,
   input  logic [AW-1:0] cfg_out_first,
   input  logic [AW-1:0] cfg_out_last,
   input  logic [AW-1:0] cfg_in_trig,
   input  logic [AW-1:0] cfg_out_low,
   input  logic          flush_in,
   input  logic          flush_out,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          tx_pop,
   output logic          tx_valid,
   output logic [DW-1:0] tx_data,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   input  logic          host_in_rp_we,
   input  logic [AW-1:0] host_in_rp,
   input  logic          host_out_wp_we,
   input  logic [AW-1:0] host_out_wp,
   output logic [AW-1:0] in_wp,
   output logic [AW-1:0] in_rp,
   output logic [AW-1:0] out_wp,
   output logic [AW-1:0] out_rp,
   output logic [AW-1:0] in_count,
   output logic [AW-1:0] out_count,
   output logic          in_empty,
   output logic          in_full,
   output logic          out_empty,
   output logic          out_full,
   output logic          in_req,
   output logic          out_req,
   output logic          overrun
);
   generate
      if (AW < 2)  begin : g_bad_aw  $error("ring_ptr_unit: AW must be at least 2"); end
      if (AW > 16) begin : g_big_aw  $error("ring_ptr_unit: AW above 16 makes the RAM too large"); end
      if (DW < 1)  begin : g_bad_dw  $error("ring_ptr_unit: DW must be positive"); end
   endgenerate

   logic rx_take;
   logic tx_take;

   assign rx_take  = rx_valid && !in_full && !flush_in;
   assign tx_take  = tx_pop && !out_empty && !flush_out;
   assign tx_valid = !out_empty;

   ring_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk     (clk),
      .wa_en   (rx_take),
      .wa_addr (in_wp),
      .wa_data (rx_data),
      .wb_en   (host_we),
      .wb_addr (host_addr),
      .wb_data (host_wdata),
      .ra_addr (out_rp),
      .ra_data (tx_data),
      .rb_addr (host_addr),
      .rb_data (host_rdata)
   );

   // channel-owned pointers
   ring_ptr #(.AW(AW)) u_in_wp (
      .clk(clk), .rst_n(rst_n), .first_a(cfg_in_first), .last_a(cfg_in_last),
      .flush(flush_in), .step(rx_take), .load(1'b0), .load_val('0), .ptr(in_wp));

   ring_ptr #(.AW(AW)) u_out_rp (
      .clk(clk), .rst_n(rst_n), .first_a(cfg_out_first), .last_a(cfg_out_last),
      .flush(flush_out), .step(tx_take), .load(1'b0), .load_val('0), .ptr(out_rp));

   // host-owned pointers
   ring_ptr #(.AW(AW)) u_in_rp (
      .clk(clk), .rst_n(rst_n), .first_a(cfg_in_first), .last_a(cfg_in_last),
      .flush(flush_in), .step(1'b0), .load(host_in_rp_we), .load_val(host_in_rp),
      .ptr(in_rp));

   ring_ptr #(.AW(AW)) u_out_wp (
      .clk(clk), .rst_n(rst_n), .first_a(cfg_out_first), .last_a(cfg_out_last),
      .flush(flush_out), .step(1'b0), .load(host_out_wp_we), .load_val(host_out_wp),
      .ptr(out_wp));

   ring_level #(.AW(AW), .RULE(REQ_ON_FILL)) u_in_lvl (
      .clk(clk), .rst_n(rst_n), .first_a(cfg_in_first), .last_a(cfg_in_last),
      .wp(in_wp), .rp(in_rp), .thr(cfg_in_trig),
      .count(in_count), .empty(in_empty), .full(in_full), .req(in_req));

   ring_level #(.AW(AW), .RULE(REQ_ON_DRAIN)) u_out_lvl (
      .clk(clk), .rst_n(rst_n), .first_a(cfg_out_first), .last_a(cfg_out_last),
      .wp(out_wp), .rp(out_rp), .thr(cfg_out_low),
      .count(out_count), .empty(out_empty), .full(out_full), .req(out_req));

   always_ff @(posedge clk) begin
      if (!rst_n || flush_in)        overrun <= 1'b0;
      else if (rx_valid && in_full)  overrun <= 1'b1;
   end

   assert_drop_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && in_full && !flush_in) |=> ($stable(in_wp) && overrun));

   assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop && out_empty && !flush_out) |=> $stable(out_rp));

   assert_flush_in_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_in |=> (in_wp == in_rp && !overrun));

   assert_host_no_touch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid && !flush_in) |=> $stable(in_wp));
endmodule

// File: tb/ring_ptr_unit_tb.sv
module ring_ptr_unit_tb;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int NV = 7;

   // rx fill of window 8..13 with trigger capped to 2
   localparam logic [7:0] V_DATA [NV] = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7};
   localparam logic [7:0] V_WP   [NV] = '{8'd9, 8'd10, 8'd11, 8'd12, 8'd13, 8'd13, 8'd13};
   localparam logic [7:0] V_CNT  [NV] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd5, 8'd5};
   localparam logic       V_REQ  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
   localparam logic       V_FULL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam logic       V_OVR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] cfg_in_first = 8'd8, cfg_in_last = 8'd13;
   logic [AW-1:0] cfg_out_first = 8'd32, cfg_out_last = 8'd39;
   logic [AW-1:0] cfg_in_trig = 8'd10, cfg_out_low = 8'd2;
   logic flush_in = 0, flush_out = 0, rx_valid = 0, tx_pop = 0;
   logic [DW-1:0] rx_data = '0;
   logic tx_valid;
   logic [DW-1:0] tx_data, host_rdata;
   logic host_we = 0, host_in_rp_we = 0, host_out_wp_we = 0;
   logic [AW-1:0] host_addr = '0, host_in_rp = '0, host_out_wp = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [AW-1:0] in_wp, in_rp, out_wp, out_rp, in_count, out_count;
   logic in_empty, in_full, out_empty, out_full, in_req, out_req, overrun;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   ring_ptr_unit #(.AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_in_first(cfg_in_first), .cfg_in_last(cfg_in_last),
      .cfg_out_first(cfg_out_first), .cfg_out_last(cfg_out_last),
      .cfg_in_trig(cfg_in_trig), .cfg_out_low(cfg_out_low),
      .flush_in(flush_in), .flush_out(flush_out),
      .rx_valid(rx_valid), .rx_data(rx_data), .tx_pop(tx_pop),
      .tx_valid(tx_valid), .tx_data(tx_data),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .host_in_rp_we(host_in_rp_we), .host_in_rp(host_in_rp),
      .host_out_wp_we(host_out_wp_we), .host_out_wp(host_out_wp),
      .in_wp(in_wp), .in_rp(in_rp), .out_wp(out_wp), .out_rp(out_rp),
      .in_count(in_count), .out_count(out_count),
      .in_empty(in_empty), .in_full(in_full),
      .out_empty(out_empty), .out_full(out_full),
      .in_req(in_req), .out_req(out_req), .overrun(overrun));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // inputs change at negedge; one edge later outputs are sampled at negedge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_strobes();
      rx_valid = 0; tx_pop = 0; host_we = 0; host_in_rp_we = 0;
      host_out_wp_we = 0; flush_in = 0; flush_out = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      tick(); tick();
      rst_n = 1;
      tick();
      // R1 reset state
      check("R1 in_wp", in_wp, 8);
      check("R1 out_rp", out_rp, 32);
      check("R1 in_empty", in_empty, 1);
      check("R1 overrun", overrun, 0);
      check("R1 tx_valid", tx_valid, 0);
      check("R9 out_req at zero", out_req, 1);

      // table walk: R2 R3 R5 R6 R8
      for (int i = 0; i < NV; i++) begin
         rx_valid = 1; rx_data = V_DATA[i];
         tick();
         rx_valid = 0;
         check("R2 in_wp", in_wp, V_WP[i]);
         check("R6 in_count", in_count, V_CNT[i]);
         check("R8 in_req", in_req, V_REQ[i]);
         check("R5 in_full", in_full, V_FULL[i]);
         check("R3 overrun", overrun, V_OVR[i]);
      end

      // R11 receive bytes visible to host; dropped bytes not stored at 13
      for (int a = 0; a < 5; a++) begin
         host_addr = AW'(8 + a);
         #1 check("R11 rx byte", host_rdata, 8'hA1 + a);
      end

      // R7 host moves the receive read pointer
      host_in_rp_we = 1; host_in_rp = 8'd12;
      tick();
      clear_strobes();
      check("R7 in_rp load", in_rp, 12);
      check("R6 in_count after load", in_count, 1);
      check("R8 in_req below", in_req, 0);
      check("R5 not full", in_full, 0);

      // R2 wrap from last to first
      rx_valid = 1; rx_data = 8'hB0;
      tick();
      clear_strobes();
      check("R2 wrap", in_wp, 8);
      check("R6 wrapped count", in_count, 2);
      host_addr = 8'd13;
      #1 check("R11 byte at last", host_rdata, 8'hB0);

      // transmit side: host fills 32..35
      for (int a = 0; a < 4; a++) begin
         host_we = 1; host_addr = AW'(32 + a); host_wdata = DW'(8'h10 + a);
         tick();
      end
      clear_strobes();
      host_out_wp_we = 1; host_out_wp = 8'd36;
      tick();
      clear_strobes();
      check("R7 out_wp load", out_wp, 36);
      check("R6 out_count", out_count, 4);
      check("R9 out_req high occupancy", out_req, 0);
      check("R4 tx_valid", tx_valid, 1);
      check("R11 tx_data", tx_data, 8'h10);

      tx_pop = 1;
      tick();
      check("R2 out_rp step", out_rp, 33);
      check("R11 tx_data next", tx_data, 8'h11);
      tick(); tick();
      clear_strobes();
      check("R6 out_count drained", out_count, 1);
      check("R9 out_req low", out_req, 1);

      // R10 flush of transmit wins over a host load
      flush_out = 1; host_out_wp_we = 1; host_out_wp = 8'd38;
      tick();
      clear_strobes();
      check("R10 out_rp", out_rp, 32);
      check("R10 out_wp", out_wp, 32);
      check("R4 out_empty", out_empty, 1);
      check("R4 tx_valid empty", tx_valid, 0);

      // R4 pop on empty ignored
      tx_pop = 1;
      tick();
      clear_strobes();
      check("R4 pop ignored", out_rp, 32);

      // R5 full: read at first, write at last
      host_out_wp_we = 1; host_out_wp = 8'd39;
      tick();
      clear_strobes();
      check("R5 full first/last", out_full, 1);
      check("R6 full count", out_count, 7);

      tx_pop = 1;
      tick();
      clear_strobes();
      check("R5 not full after pop", out_full, 0);
      check("R6 count after pop", out_count, 6);

      // R5 full: write one below read (wrapped)
      host_out_wp_we = 1; host_out_wp = 8'd32;
      tick();
      clear_strobes();
      check("R5 full wp=rp-1", out_full, 1);
      check("R6 count wp=rp-1", out_count, 7);

      // R10 flush of receive clears overrun
      flush_in = 1; rx_valid = 1; rx_data = 8'hCC;
      tick();
      clear_strobes();
      check("R10 in_wp", in_wp, 8);
      check("R10 in_rp", in_rp, 8);
      check("R3 overrun cleared", overrun, 0);
      check("R4 in_empty", in_empty, 1);
      check("R8 in_req empty", in_req, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule